// File: doc/BRIEF.md
# Sampled Comparator Event Packer

This block sits behind a bank of 15 level comparators whose outputs have already been sampled and deserialised. On every system clock it receives one word of 16 consecutive samples. It converts each sample from a thermometer pattern into a 4-bit count of fired comparators. It then keeps the current word and the word before it in a two-word ring, so capture has no dead time.

On any clock where at least one sample of the current word is non-zero, an internal level-0 trigger fires. The block then builds a 144-bit record from three parts: the 16-bit coarse time of that word, the previous word and the current word. It pushes the record into a derandomising FIFO.

A short hit and a long waveform use the same path. A waveform simply yields one record per clock for as long as the trigger holds. Records are drained through a valid/ready port. A record that finds the FIFO full is dropped whole, and a sticky overflow flag is raised. Thermometer patterns with a gap are still converted, and they raise a sticky error flag.

Top module: `sample_event_packer`

## Requirements
- R1: Each 15-bit sample (sample k at input bits [15k+14:15k], sample 0 earliest) becomes a 4-bit code equal to the number of its set bits. A valid thermometer pattern with n low bits set yields code n, from 0 to 15.
- R2: A sample in which some bit is set while the bit below it is clear is still coded by counting its ones. It also sets `therm_err_o` one clock later, and the flag stays set until reset.
- R3: A word whose 16 codes are all zero writes nothing to the FIFO. With an empty FIFO, `rd_valid_o` stays low during such words.
- R4: The record layout is as follows. Bits [143:128] hold the coarse time. Bits [127:64] hold the previous word and bits [63:0] hold the current word. Within a word, sample k sits at bits [4k+3:4k]. The record is readable two clocks after its word is presented.
- R5: The coarse time of a word equals the number of clocks since reset was released, counted when the word is presented, modulo 65536.
- R6: Consecutive triggered words each produce a record. The previous-word field of each record equals the current-word field of the record before it, with no skipped word.
- R7: The FIFO holds up to FIFO_DEPTH records (default 16) and returns them in write order.
- R8: A triggered word that meets a full FIFO is dropped entirely, and it sets `overflow_o`, which stays set until reset. Records already stored are unaffected.
- R9: While `rd_valid_o` is high and `rd_ready_i` is low, `rd_data_o` and `rd_valid_o` hold their values. A record leaves on a clock with both high.
- R10: After reset, `rd_valid_o`, `therm_err_o` and `overflow_o` are low and the coarse time restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samples_i | input | 240 | 16 thermometer samples of 15 bits, sample 0 in the low bits |
| rd_ready_i | input | 1 | Reader accepts the presented record |
| rd_valid_o | output | 1 | A record is presented |
| rd_data_o | output | 144 | Presented record |
| therm_err_o | output | 1 | Sticky flag for a non-thermometer sample |
| overflow_o | output | 1 | Sticky flag for a record dropped on a full FIFO |

## Verification
The bench keeps the sample, level and timestamp widths at their defaults. It shrinks FIFO_DEPTH to 6, a depth that is not a power of two. With that depth the full condition and the whole-record drop are reached after a handful of hits, and the pointer wrap at an odd depth is exercised on every drain. Because the timestamp stays at 16 bits, the bench can idle past 65536 clocks and check the coarse-time wrap within the run. Read readiness follows a pseudo-random pattern, so records are accepted both back to back and after stalls.

// File: rtl/sep_pkg.sv
// Package: shared defaults and the record-width helper for the event packer.
// Assumes: record = timestamp, previous word, current word (MSB to LSB).
package sep_pkg;
    localparam int unsigned SEP_N_SAMP = 16;
    localparam int unsigned SEP_N_LVL  = 15;
    localparam int unsigned SEP_TS_W   = 16;
    localparam int unsigned SEP_DEPTH  = 16;

    // Width of one timestamped record for a given geometry.
    function automatic int unsigned sep_rec_w(input int unsigned n_samp,
                                              input int unsigned code_w,
                                              input int unsigned ts_w);
        return ts_w + 2 * n_samp * code_w;
    endfunction
endpackage

// File: rtl/sep_therm_enc.sv
// Module: sep_therm_enc
// Converts one comparator sample to a binary count of set bits and flags
// patterns that are not a clean thermometer (a set bit above a clear one).
// Assumes: bit 0 is the lowest threshold.
module sep_therm_enc #(
    parameter int unsigned N_LVL  = 15,
    parameter int unsigned CODE_W = $clog2(N_LVL + 1)
) (
    input  logic [N_LVL-1:0]  therm_i,
    output logic [CODE_W-1:0] code_o,
    output logic              bad_o
);
    // Count ones: exact for valid codes, a defined fallback for broken ones.
    always_comb begin
        code_o = '0;
        for (int i = 0; i < int'(N_LVL); i++) begin
            code_o = code_o + CODE_W'(therm_i[i]);
        end
    end

    // Detect any gap below a set comparator.
    always_comb begin
        bad_o = 1'b0;
        for (int i = 1; i < int'(N_LVL); i++) begin
            if (therm_i[i] && !therm_i[i-1]) bad_o = 1'b1;
        end
    end
endmodule

// File: rtl/sep_capture.sv
// Module: sep_capture
// Encodes all samples of a word, keeps a two-word ring (previous, current),
// raises the level-0 trigger for any non-zero word and tags it with the
// free-running coarse time. Assumes one new word on every clock.
module sep_capture #(
    parameter int unsigned N_SAMP = 16,
    parameter int unsigned N_LVL  = 15,
    parameter int unsigned CODE_W = $clog2(N_LVL + 1),
    parameter int unsigned TS_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SAMP*N_LVL-1:0]  samples_i,
    output logic [N_SAMP*CODE_W-1:0] cur_o,
    output logic [N_SAMP*CODE_W-1:0] prv_o,
    output logic [TS_W-1:0]          ts_o,
    output logic                     trig_o,
    output logic                     err_o
);
    localparam int unsigned WORD_W = N_SAMP * CODE_W;

    logic [WORD_W-1:0] enc_word;
    logic [N_SAMP-1:0] bad_vec;
    logic [N_SAMP-1:0] nz_vec;
    logic [WORD_W-1:0] cur_q, prv_q;
    logic [TS_W-1:0]   ts_cnt, ts_q;
    logic              trig_q, err_q;

    // One encoder per sample slot.
    for (genvar k = 0; k < int'(N_SAMP); k++) begin : g_enc
        sep_therm_enc #(.N_LVL(N_LVL), .CODE_W(CODE_W)) u_enc (
            .therm_i (samples_i[k*N_LVL +: N_LVL]),
            .code_o  (enc_word[k*CODE_W +: CODE_W]),
            .bad_o   (bad_vec[k])
        );
        assign nz_vec[k] = |enc_word[k*CODE_W +: CODE_W];
    end

    // Ring shift, trigger, coarse time and sticky error in one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            prv_q  <= '0;
            trig_q <= 1'b0;
            ts_cnt <= '0;
            ts_q   <= '0;
            err_q  <= 1'b0;
        end else begin
            cur_q  <= enc_word;
            prv_q  <= cur_q;
            trig_q <= |nz_vec;
            ts_q   <= ts_cnt;
            ts_cnt <= ts_cnt + 1'b1;
            if (|bad_vec) err_q <= 1'b1;
        end
    end

    assign cur_o  = cur_q;
    assign prv_o  = prv_q;
    assign ts_o   = ts_q;
    assign trig_o = trig_q;
    assign err_o  = err_q;

    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ts_cnt == TS_W'($past(ts_cnt) + 1'b1)); // R5
    AST_RING_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> prv_q == $past(cur_q)); // R6
    AST_TRIG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |-> cur_q != '0); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R2
endmodule

// File: rtl/sep_fifo.sv
// Module: sep_fifo
// Record-wide derandomising FIFO. A write request on a full FIFO is dropped
// whole and sets a sticky overflow flag; a read frees space one clock later.
// Assumes DEPTH >= 1; any depth, not only powers of two.
module sep_fifo #(
    parameter int unsigned WIDTH = 144,
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req_i,
    input  logic [WIDTH-1:0] wr_data_i,
    output logic             rd_valid_o,
    output logic [WIDTH-1:0] rd_data_o,
    input  logic             rd_ready_i,
    output logic             ovf_o
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             ovf_q;
    logic             full, do_wr, do_rd;

    assign full       = (count == CW'(DEPTH));
    assign do_wr      = wr_req_i && !full;
    assign rd_valid_o = (count != '0);
    assign do_rd      = rd_valid_o && rd_ready_i;
    assign rd_data_o  = mem[rd_ptr];
    assign ovf_o      = ovf_q;

    // Storage array: written only for accepted records.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data_i;
    end

    // Pointers, occupancy and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr_req_i && full) ovf_q <= 1'b1;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R7
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_req_i && !rd_ready_i |=> full && ovf_q); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q); // R8
endmodule

// File: rtl/sample_event_packer.sv
// Module: sample_event_packer (top)
// Packs 16 thermometer samples per clock into 144-bit timestamped records,
// writes them only on trigger clocks and queues them for a valid/ready reader.
// Assumes samples_i carries a fresh word on every clock.
module sample_event_packer #(
    parameter int unsigned N_SAMP     = sep_pkg::SEP_N_SAMP,
    parameter int unsigned N_LVL      = sep_pkg::SEP_N_LVL,
    parameter int unsigned TS_W       = sep_pkg::SEP_TS_W,
    parameter int unsigned FIFO_DEPTH = sep_pkg::SEP_DEPTH,
    localparam int unsigned CODE_W    = $clog2(N_LVL + 1),
    localparam int unsigned REC_W     = sep_pkg::sep_rec_w(N_SAMP, CODE_W, TS_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SAMP*N_LVL-1:0] samples_i,
    input  logic                    rd_ready_i,
    output logic                    rd_valid_o,
    output logic [REC_W-1:0]        rd_data_o,
    output logic                    therm_err_o,
    output logic                    overflow_o
);
    localparam int unsigned WORD_W = N_SAMP * CODE_W;

    logic [WORD_W-1:0] cur_w, prv_w;
    logic [TS_W-1:0]   ts_w;
    logic              trig;

    // Sample encoding, two-word ring, trigger and coarse time.
    sep_capture #(
        .N_SAMP(N_SAMP), .N_LVL(N_LVL), .CODE_W(CODE_W), .TS_W(TS_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .samples_i (samples_i),
        .cur_o     (cur_w),
        .prv_o     (prv_w),
        .ts_o      (ts_w),
        .trig_o    (trig),
        .err_o     (therm_err_o)
    );

    // Shared path for single hits and waveforms.
    sep_fifo #(.WIDTH(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req_i   (trig),
        .wr_data_i  ({ts_w, prv_w, cur_w}),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o),
        .rd_ready_i (rd_ready_i),
        .ovf_o      (overflow_o)
    );
endmodule

// File: tb/test_sample_event_packer.sv
// Scoreboard bench: a driver task presents words and queues expected
// records; a monitor pops and compares on every accepted read.
module test_sample_event_packer;
    localparam int NS = 16, NL = 15, CW = 4, TW = 16, DEPTH = 6;
    localparam int WW = NS * CW, RW = TW + 2 * WW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS*NL-1:0]  samples = '0;
    logic              rd_ready = 1'b0;
    logic              rd_valid;
    logic [RW-1:0]     rd_data;
    logic              therm_err, overflow;

    sample_event_packer #(.FIFO_DEPTH(DEPTH)) i_sample_event_packer (
        .clk(clk), .rst_n(rst_n), .samples_i(samples), .rd_ready_i(rd_ready),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data),
        .therm_err_o(therm_err), .overflow_o(overflow)
    );

    always #2.5 clk = ~clk;

    int          n_tests = 0, n_fail = 0;
    int          cyc = 0;
    logic [RW-1:0] exp_q[$];
    string       tag_q[$];
    logic [WW-1:0] prev_exp = '0;
    logic        hold_rd = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit          done = 1'b0;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [RW-1:0] act,
                       input logic [RW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NL-1:0] therm(input int c);
        return NL'((32'd1 << c) - 1);
    endfunction

    // Present one word (raw comparator bits, expected codes) for one clock.
    task automatic drive_word(input logic [NS*NL-1:0] raw, input logic [WW-1:0] codes,
                              input string tag);
        @(negedge clk);
        samples = raw;
        if (codes != '0 && exp_q.size() < DEPTH) begin
            exp_q.push_back({TW'(cyc), prev_exp, codes});
            tag_q.push_back(tag);
        end
        prev_exp = codes;
    endtask

    task automatic drive_codes(input logic [WW-1:0] codes, input string tag);
        logic [NS*NL-1:0] raw;
        for (int k = 0; k < NS; k++) raw[k*NL +: NL] = therm(int'(codes[k*CW +: CW]));
        drive_word(raw, codes, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive_word('0, '0, "idle");
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && (exp_q.size() != 0 || rd_valid); i++) idle(1);
        idle(2);
    endtask

    // Monitor: choose readiness, then compare the record about to be taken.
    always @(negedge clk) begin
        if (rst_n) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rd_ready = hold_rd ? 1'b0 : (lfsr[0] | lfsr[3]);
            #1;
            if (rd_valid && rd_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected record", rd_data, '0);
                end else begin
                    chk(rd_data === exp_q[0], tag_q[0], rd_data, exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(5 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [WW-1:0]    w;
        logic [NS*NL-1:0] raw;
        logic [RW-1:0]    held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        // R10: reset state
        chk(!rd_valid, "R10 rd_valid after reset", RW'(rd_valid), '0);
        chk(!therm_err, "R10 error flag after reset", RW'(therm_err), '0);
        chk(!overflow, "R10 overflow after reset", RW'(overflow), '0);
        idle(2);

        // R1/R4: single hit, one sample of code 7 in slot 5
        w = '0; w[5*CW +: CW] = 4'd7;
        drive_codes(w, "R4 single-hit layout");
        drain();
        // R3: all-zero words write nothing
        for (int i = 0; i < 5; i++) begin
            idle(1); #2;
            chk(!rd_valid, "R3 idle word suppressed", RW'(rd_valid), '0);
        end

        // R1: full scale and a ramp of every code 0..15
        drive_codes({NS{4'hF}}, "R1 full-scale codes");
        for (int k = 0; k < NS; k++) w[k*CW +: CW] = CW'(k);
        drive_codes(w, "R1 ramp codes");
        drain();

        // R6: long waveform, 8 consecutive triggered words
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < NS; k++) w[k*CW +: CW] = CW'((i * 5 + k * 3) % 16);
            drive_codes(w, "R6 waveform chain");
        end
        drain();
        // R7: scattered hits with gaps, order preserved
        for (int i = 0; i < 4; i++) begin
            w = '0; w[(i*4)*CW +: CW] = CW'(i + 1);
            drive_codes(w, "R7 ordered hits");
            idle(i);
        end
        drain();

        // R2: broken thermometer, four ones with gaps -> code 4
        chk(!therm_err, "R2 error flag clear before", RW'(therm_err), '0);
        raw = '0; raw[3*NL +: NL] = 15'b000_0000_0010_1101;
        w = '0; w[3*CW +: CW] = 4'd4;
        drive_word(raw, w, "R2 broken code counted");
        idle(1); #2;
        chk(therm_err, "R2 error flag set", RW'(therm_err), 1);
        drain(); #2;
        chk(therm_err, "R2 error flag sticky", RW'(therm_err), 1);

        // R8/R9: reader stalled, DEPTH+3 hits, extras dropped
        chk(!overflow, "R8 overflow clear before", RW'(overflow), '0);
        hold_rd = 1'b1;
        for (int i = 0; i < DEPTH + 3; i++) begin
            w = '0; w[(i % NS)*CW +: CW] = CW'(i + 2);
            drive_codes(w, "R8 kept before full");
        end
        idle(2); #2;
        chk(overflow, "R8 overflow set", RW'(overflow), 1);
        held = rd_data;
        chk(rd_valid && held === exp_q[0], "R9 head record", rd_data, exp_q[0]);
        idle(3); #2;
        chk(rd_valid && rd_data === held, "R9 held while stalled", rd_data, held);
        hold_rd = 1'b0;
        drain(); #2;
        chk(exp_q.size() == 0 && !rd_valid, "R7 exactly DEPTH records kept",
            RW'(exp_q.size()), '0);
        chk(overflow, "R8 overflow sticky", RW'(overflow), 1);

        // R5: coarse time wrap past 65536 clocks
        while (cyc < 65536 + 7) idle(1);
        w = '0; w[0 +: CW] = 4'd9;
        drive_codes(w, "R5 timestamp after wrap");
        drain();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule